// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the synchronous front end and word store of a small burst SRAM. On every rising clock edge it samples three chip selects, two competing start strobes, an advance strobe, the write controls and the address. From these it decides which kind of cycle is running: deselect, start of a read, start of a write, continue on the next burst address, or hold on the current one. It applies byte-lane writes to a parameterised word array. It returns read data through a two-stage register pipeline.

The bus-side data pin is split into a registered data output and an output-valid flag. The valid flag follows the output-enable input without waiting for a clock edge. The order of burst addresses comes from an external sequencer. The block presents its current word address on `cur_addr_o`. On an advancing edge it loads whatever that sequencer offers on `next_addr_i`.

The processor-side strobe always starts a read, and it is gated by the main chip select. The controller-side strobe is honoured only while the processor-side strobe is inactive or blocked, and it samples the write controls on its own edge. After a deselect, the outputs stay driven for one more cycle before they turn off.

Top module: `burst_sram_ctrl`

## Requirements
- R1: After reset, `rdata_vld_o` is low, `cur_addr_o` is 0, `rdata_o` is 0, and no burst is active.
- R2: When `cpu_strobe_n_i`=0, `sel0_n_i`=0, `sel1_i`=1 and `sel2_n_i`=0 on an edge, a read of `addr_i` starts on that edge. All write controls are ignored on that edge, so the addressed word is unchanged.
- R3: `ctl_strobe_n_i`=0 starts a cycle only when `cpu_strobe_n_i`=1 or `sel0_n_i`=1. On that edge the write controls are sampled: any lane enabled starts a write of `wdata_i` to `addr_i`, and no lane enabled starts a read. If both strobes are low with the main select active, the processor-side read wins.
- R4: A deselect occurs in two cases: `ctl_strobe_n_i`=0 while `sel0_n_i`=1, or either accepted strobe while `sel1_i`=0 or `sel2_n_i`=1. A deselect ends the burst. `cpu_strobe_n_i`=0 with `sel0_n_i`=1 and `ctl_strobe_n_i`=1 starts nothing.
- R5: With both strobes inactive during an active burst, `advance_n_i`=0 loads `next_addr_i` as the current address and `advance_n_i`=1 keeps it, whatever `sel0_n_i` is. Each such edge is a write (when lanes are enabled) or a read at that address. With no active burst, these edges neither read, write nor move the address.
- R6: Lane enables: `all_wr_n_i`=0 enables all four lanes. Otherwise `lane_en_n_i`=0 enables lane n when `lane_sel_n_i[n]`=0. Lane n covers data bits [n*W +: W], with W = DATA_W/4. No enabled lane means read.
- R7: For a read whose address is registered on edge k, `rdata_o` holds that word after edge k+1, and the output is driven from edge k+1 for one cycle.
- R8: `rdata_vld_o` is high only while the output is driven and `out_en_n_i`=0. It follows `out_en_n_i` without a clock edge.
- R9: An edge that performs a write turns the output off (`rdata_vld_o`=0) for the following cycle, regardless of `out_en_n_i`.
- R10: After a deselect on edge k, a read issued on edge k-1 is still driven after edge k. The output is off after edge k+1.
- R11: When a read is pending from edge k and edge k+1 writes the same word, `rdata_o` after edge k+1 holds the word as stored before that write.
- R12: Stored words keep their values across deselect cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, all sampling on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel0_n_i | input | 1 | Main chip select, active low; gates the processor-side strobe |
| sel1_i | input | 1 | Chip select, active high |
| sel2_n_i | input | 1 | Chip select, active low |
| cpu_strobe_n_i | input | 1 | Processor-side start strobe, active low, always a read |
| ctl_strobe_n_i | input | 1 | Controller-side start strobe, active low |
| advance_n_i | input | 1 | Advance to the next burst address, active low |
| all_wr_n_i | input | 1 | Write every lane, active low |
| lane_en_n_i | input | 1 | Allow per-lane writes, active low |
| lane_sel_n_i | input | 4 | Per-lane write select, active low |
| addr_i | input | ADDR_W | Word address for a started cycle |
| next_addr_i | input | ADDR_W | Next burst address from the external sequencer |
| wdata_i | input | DATA_W | Write data |
| out_en_n_i | input | 1 | Output enable, active low, not clocked |
| cur_addr_o | output | ADDR_W | Current registered word address |
| rdata_o | output | DATA_W | Registered read data |
| rdata_vld_o | output | 1 | Read data is being driven |

## Verification
Two functions can meet on a single edge. One is the output-register load of a read issued one edge earlier. The other is a write sampled on that same edge, both for its turn-off of the output and for its store into the word just read. This is provoked by starting a read and, on the very next edge, starting a controller-side write to the same word. In the same way, a hold-write is placed right after a pipelined read. The result is judged in three places: the data register must show the old word, the valid flag must be low in that cycle, and a later read must return the new word.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_START_RD = 3'd1,
        CYC_START_WR = 3'd2,
        CYC_ADVANCE  = 3'd3,
        CYC_HOLD     = 3'd4
    } cyc_e;

    localparam int unsigned NUM_LANES = 4;

endpackage

// File: rtl/bsram_cyc_decode.sv
module bsram_cyc_decode
    import bsram_pkg::*;
(
    input  logic sel0_n_i,
    input  logic sel1_i,
    input  logic sel2_n_i,
    input  logic cpu_strobe_n_i,
    input  logic ctl_strobe_n_i,
    input  logic advance_n_i,
    input  logic any_we_i,
    output cyc_e kind_o,
    output logic cpu_start_o
);

    logic chip_on;
    logic cpu_go;
    logic ctl_go;

    always_comb begin
        chip_on = !sel0_n_i && sel1_i && !sel2_n_i;
        // the main select blocks the processor-side strobe
        cpu_go  = !cpu_strobe_n_i && !sel0_n_i;
        // the controller-side strobe only counts while the other one is idle or blocked
        ctl_go  = !ctl_strobe_n_i && !cpu_go;

        if (cpu_go) begin
            kind_o = chip_on ? CYC_START_RD : CYC_DESEL;
        end else if (ctl_go) begin
            if (!chip_on) begin
                kind_o = CYC_DESEL;
            end else begin
                kind_o = any_we_i ? CYC_START_WR : CYC_START_RD;
            end
        end else begin
            kind_o = advance_n_i ? CYC_HOLD : CYC_ADVANCE;
        end
        cpu_start_o = cpu_go;
    end

endmodule

// File: rtl/bsram_wr_decode.sv
module bsram_wr_decode #(
    parameter int unsigned LANES = 4
) (
    input  logic             all_wr_n_i,
    input  logic             lane_en_n_i,
    input  logic [LANES-1:0] lane_sel_n_i,
    output logic [LANES-1:0] lane_we_o,
    output logic             any_we_o
);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_we_o[i] = !all_wr_n_i || (!lane_en_n_i && !lane_sel_n_i[i]);
        end
        any_we_o = |lane_we_o;
    end

endmodule

// File: rtl/bsram_lanes.sv
module bsram_lanes #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 36,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LANES-1:0]  we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned LANE_W = DATA_W / LANES;
    localparam int unsigned DEPTH  = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] rd_d;
        logic [LANE_W-1:0] rd_q;

        // contents carry no reset; they survive deselects
        always_ff @(posedge clk_i) begin
            if (we_i[g]) begin
                store[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        always_comb begin
            rd_d = re_i ? store[raddr_i] : rd_q;
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                rd_q <= '0;
            end else begin
                rd_q <= rd_d;
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 36
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sel0_n_i,
    input  logic                 sel1_i,
    input  logic                 sel2_n_i,
    input  logic                 cpu_strobe_n_i,
    input  logic                 ctl_strobe_n_i,
    input  logic                 advance_n_i,
    input  logic                 all_wr_n_i,
    input  logic                 lane_en_n_i,
    input  logic [NUM_LANES-1:0] lane_sel_n_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [ADDR_W-1:0]    next_addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 out_en_n_i,
    output logic [ADDR_W-1:0]    cur_addr_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 rdata_vld_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              active;
        logic              rd_pend;
        logic              drive;
    } st_t;

    st_t                  st_d;
    st_t                  st_q;
    cyc_e                 kind;
    logic                 cpu_start;
    logic [NUM_LANES-1:0] lane_we;
    logic                 any_we;
    logic                 wr_now;
    logic [ADDR_W-1:0]    eff_addr;
    logic [NUM_LANES-1:0] arr_we;

    bsram_wr_decode #(
        .LANES(NUM_LANES)
    ) u_wr_decode (
        .all_wr_n_i  (all_wr_n_i),
        .lane_en_n_i (lane_en_n_i),
        .lane_sel_n_i(lane_sel_n_i),
        .lane_we_o   (lane_we),
        .any_we_o    (any_we)
    );

    bsram_cyc_decode u_cyc_decode (
        .sel0_n_i      (sel0_n_i),
        .sel1_i        (sel1_i),
        .sel2_n_i      (sel2_n_i),
        .cpu_strobe_n_i(cpu_strobe_n_i),
        .ctl_strobe_n_i(ctl_strobe_n_i),
        .advance_n_i   (advance_n_i),
        .any_we_i      (any_we),
        .kind_o        (kind),
        .cpu_start_o   (cpu_start)
    );

    always_comb begin
        st_d     = st_q;
        wr_now   = 1'b0;
        eff_addr = st_q.addr;

        unique case (kind)
            CYC_DESEL: begin
                st_d.active  = 1'b0;
                st_d.rd_pend = 1'b0;
            end
            CYC_START_RD: begin
                eff_addr     = addr_i;
                st_d.active  = 1'b1;
                st_d.rd_pend = 1'b1;
            end
            CYC_START_WR: begin
                eff_addr     = addr_i;
                st_d.active  = 1'b1;
                st_d.rd_pend = 1'b0;
                wr_now       = 1'b1;
            end
            default: begin
                if (st_q.active) begin
                    eff_addr     = (kind == CYC_ADVANCE) ? next_addr_i : st_q.addr;
                    wr_now       = any_we;
                    st_d.rd_pend = !any_we;
                end else begin
                    st_d.rd_pend = 1'b0;
                end
            end
        endcase

        st_d.addr  = eff_addr;
        // second pipeline stage: drive what the previous edge addressed, unless writing now
        st_d.drive = st_q.rd_pend && !wr_now;
        arr_we     = wr_now ? lane_we : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    bsram_lanes #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LANES (NUM_LANES)
    ) u_lanes (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (arr_we),
        .waddr_i(eff_addr),
        .wdata_i(wdata_i),
        .re_i   (st_q.rd_pend),
        .raddr_i(st_q.addr),
        .rdata_o(rdata_o)
    );

    assign cur_addr_o  = st_q.addr;
    assign rdata_vld_o = st_q.drive && !out_en_n_i;

    // R2
    cpu_start_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_start |-> (arr_we == '0));

    // R7
    read_to_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.rd_pend && !wr_now) |=> st_q.drive);

    // R9
    write_blocks_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_now |=> !rdata_vld_o);

    // R10
    deselect_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind == CYC_DESEL) |=> ##1 !rdata_vld_o);

    // R5
    hold_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kind == CYC_HOLD) |=> $stable(cur_addr_o));

endmodule

// File: tb/burst_sram_ctrl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctrl_tb;

    localparam int AW    = 6;
    localparam int DW    = 36;
    localparam int LW    = DW / 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          t_s0n, t_s1, t_s2n, t_cpu_n, t_ctl_n, t_adv_n;
    logic          t_gw_n, t_bwe_n, t_oe_n;
    logic [3:0]    t_bsel_n;
    logic [AW-1:0] t_addr;
    logic [DW-1:0] t_wd;
    logic [AW-1:0] nxt_addr;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] rdata;
    logic          rvld;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    // reference model state
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_addr = '0;
    bit            m_active = 0;
    bit            m_pend = 0;
    bit            m_drive = 0;
    logic [DW-1:0] m_dout = '0;

    always #2.5 clk = ~clk;

    // external sequencer: linear order inside a four-word group
    assign nxt_addr = {cur_addr[AW-1:2], cur_addr[1:0] + 2'd1};

    burst_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .sel0_n_i(t_s0n), .sel1_i(t_s1), .sel2_n_i(t_s2n),
        .cpu_strobe_n_i(t_cpu_n), .ctl_strobe_n_i(t_ctl_n), .advance_n_i(t_adv_n),
        .all_wr_n_i(t_gw_n), .lane_en_n_i(t_bwe_n), .lane_sel_n_i(t_bsel_n),
        .addr_i(t_addr), .next_addr_i(nxt_addr), .wdata_i(t_wd), .out_en_n_i(t_oe_n),
        .cur_addr_o(cur_addr), .rdata_o(rdata), .rdata_vld_o(rvld)
    );

    function automatic logic [DW-1:0] pat(input int a);
        logic [63:0] h;
        h = 64'(a + 1) * 64'h9E37_79B9_7F4A_7C15;
        return h[DW+6:7];
    endfunction

    // behavioural model, updated on each rising edge from the driven inputs
    always @(posedge clk) begin
        if (rst_n) begin
            bit            on, cpu, ctl, any, wr, rd, start, adv_mv;
            logic [DW-1:0] mask;
            logic [AW-1:0] where;
            on   = !t_s0n && t_s1 && !t_s2n;
            mask = '0;
            for (int l = 0; l < 4; l++) begin
                if (!t_gw_n || (!t_bwe_n && !t_bsel_n[l])) mask[l*LW +: LW] = '1;
            end
            any    = (mask != '0);
            cpu    = !t_cpu_n && !t_s0n;
            ctl    = !t_ctl_n && !cpu;
            wr     = 0;
            rd     = 0;
            start  = 0;
            adv_mv = 0;
            where  = m_addr;
            if (cpu || ctl) begin
                if (on) begin
                    start = 1;
                    where = t_addr;
                    wr    = ctl && any;
                    rd    = !wr;
                end
            end else if (m_active) begin
                adv_mv = !t_adv_n;
                where  = adv_mv ? {m_addr[AW-1:2], m_addr[1:0] + 2'd1} : m_addr;
                wr     = any;
                rd     = !any;
            end
            if (m_pend) m_dout = m_mem[m_addr];
            m_drive = m_pend && !wr;
            if (wr) m_mem[where] = (m_mem[where] & ~mask) | (t_wd & mask);
            if ((cpu || ctl) && !on) m_active = 0;
            else if (start) m_active = 1;
            m_pend = rd;
            m_addr = where;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        t_s0n = 0; t_s1 = 1; t_s2n = 0;
        t_cpu_n = 1; t_ctl_n = 1; t_adv_n = 1;
        t_gw_n = 1; t_bwe_n = 1; t_bsel_n = 4'hF;
        t_addr = '0; t_wd = '0; t_oe_n = 0;
    endtask

    task automatic tick(input string tag);
        bit ev;
        @(posedge clk);
        @(negedge clk);
        ev = m_drive && !t_oe_n;
        chk(cur_addr == m_addr, {tag, " address"}, DW'(cur_addr), DW'(m_addr));
        chk(rvld == ev, {tag, " valid"}, DW'(rvld), DW'(ev));
        chk(rdata == m_dout, {tag, " data"}, rdata, m_dout);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] exp_w;
        quiet();
        t_s0n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(rvld == 1'b0, "R1 valid after reset", DW'(rvld), '0);
        chk(cur_addr == '0, "R1 address after reset", DW'(cur_addr), '0);
        chk(rdata == '0, "R1 data after reset", rdata, '0);
        quiet(); tick("R1");
        quiet(); tick("R1");

        // fill every word through controller-side writes (R3)
        for (int a = 0; a < DEPTH; a++) begin
            quiet(); t_ctl_n = 0; t_gw_n = 0; t_addr = AW'(a); t_wd = pat(a);
            tick("R3 fill");
        end

        // R12: deselects in between must not disturb storage
        for (int i = 0; i < 3; i++) begin
            quiet(); t_s0n = 1; t_ctl_n = 0; tick("R12 deselect");
        end

        // R2: processor start ignores the write controls
        quiet(); t_cpu_n = 0; t_addr = 6'd5; t_gw_n = 0; t_wd = '1; tick("R2");
        quiet(); tick("R7");
        chk(rvld == 1'b1, "R7 driven one edge after address", DW'(rvld), 1);
        chk(rdata == pat(5), "R2 write ignored on start edge", rdata, pat(5));

        // R5: advance through the group, then hold
        for (int i = 0; i < 4; i++) begin
            quiet(); t_adv_n = 0; t_s0n = (i == 2); tick("R5 advance");
        end
        chk(cur_addr == 6'd5, "R5 wrapped advance address", DW'(cur_addr), 5);
        quiet(); tick("R5 hold");
        chk(cur_addr == 6'd5, "R5 hold keeps address", DW'(cur_addr), 5);

        // R8: output enable acts without a clock edge
        quiet(); t_oe_n = 1; tick("R8");
        chk(rvld == 1'b0, "R8 disabled by out_en", DW'(rvld), 0);
        #0.5 t_oe_n = 0;
        #0.5 chk(rvld == 1'b1, "R8 enable without edge", DW'(rvld), 1);

        // R10: deselect during a read burst
        quiet(); t_ctl_n = 0; t_s2n = 1; tick("R10");
        chk(rvld == 1'b1, "R10 still driven after deselect edge", DW'(rvld), 1);
        quiet(); tick("R10");
        chk(rvld == 1'b0, "R10 off one edge later", DW'(rvld), 0);

        // R4: blocked processor strobe and failing selects start nothing
        quiet(); t_s0n = 1; t_cpu_n = 0; t_addr = 6'd9; tick("R4 blocked");
        quiet(); tick("R4");
        chk(rvld == 1'b0, "R4 blocked strobe no read", DW'(rvld), 0);
        quiet(); t_s1 = 0; t_cpu_n = 0; t_addr = 6'd9; tick("R4 sel1");
        quiet(); tick("R4");
        chk(rvld == 1'b0, "R4 sel1 low no read", DW'(rvld), 0);
        // R5: inactive continue must not write
        quiet(); t_adv_n = 0; t_gw_n = 0; t_wd = '0; tick("R5 inactive");

        // R3: both strobes low, processor read wins, no write
        quiet(); t_cpu_n = 0; t_ctl_n = 0; t_gw_n = 0; t_addr = 6'd9; t_wd = '0;
        tick("R3 priority");
        quiet(); tick("R3");
        chk(rdata == pat(9), "R3 processor strobe wins", rdata, pat(9));

        // R6: lanes 0 and 2 only
        exp_w = pat(12);
        exp_w[0 +: LW] = '1;
        exp_w[2*LW +: LW] = '1;
        quiet(); t_ctl_n = 0; t_addr = 6'd12; t_bwe_n = 0; t_bsel_n = 4'b1010; t_wd = '1;
        tick("R6 lane write");
        quiet(); t_ctl_n = 0; t_addr = 6'd12; t_bwe_n = 1; t_bsel_n = 4'b0000;
        tick("R6 lane enable off is read");
        quiet(); tick("R6");
        chk(rdata == exp_w, "R6 lane merge", rdata, exp_w);

        // R9: hold-write right after a read turns the output off
        quiet(); t_gw_n = 0; t_wd = 36'h1_2345_6789; tick("R9");
        chk(rvld == 1'b0, "R9 write turns output off", DW'(rvld), 0);

        // R11: read then immediate write of the same word
        quiet(); t_cpu_n = 0; t_addr = 6'd20; tick("R11");
        quiet(); t_ctl_n = 0; t_gw_n = 0; t_addr = 6'd20; t_wd = 36'hA_BCDE_F012; tick("R11");
        chk(rdata == pat(20), "R11 old word returned", rdata, pat(20));
        quiet(); t_cpu_n = 0; t_addr = 6'd20; tick("R11");
        quiet(); tick("R11");
        chk(rdata == 36'hA_BCDE_F012, "R11 new word afterwards", rdata, 36'hA_BCDE_F012);

        // R12: storage after many deselects
        for (int i = 0; i < 5; i++) begin
            quiet(); t_s0n = 1; t_ctl_n = 0; tick("R12");
        end
        quiet(); t_cpu_n = 0; t_addr = 6'd30; tick("R12");
        quiet(); tick("R12");
        chk(rdata == pat(30), "R12 word retained", rdata, pat(30));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule